// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer whose write side and read side run on separate, unrelated clocks. A producer pushes one word per write-clock edge while its active-low write strobe is low. A consumer pulls one word per read-clock edge into a registered output while its active-low read strobe is low. The output register is gated by an active-low output enable. One active-low reset, asynchronous to both clocks, clears both sides.

Five active-low status outputs describe the fill level: empty, almost-empty, half-full, almost-full and full. The almost-empty and almost-full thresholds come from two offset values held by a companion register block. A select input picks between those offsets and built-in defaults that depend on the depth. Depth is a power-of-two parameter from 256 to 4096. Pointers cross between the clock domains as Gray code through two-stage synchronizers.

Each flag is produced in one domain from that domain's own pointer and a synchronized copy of the other side's pointer. A flag therefore sets on the edge of the side that fills or drains towards the condition. It releases a few cycles after the other side has moved the level back. The offsets are expected to be static while the buffer is running, and are changed only while reset is held.

Top module: `xclk_fifo`

## Requirements
- R1: While and after reset, with no traffic: empty_n = 0, aempty_n = 0, half_n = 1, afull_n = 1, full_n = 1, and rd_data = 0 with out_en_n = 0.
- R2: Words leave the buffer in exactly the order in which they were accepted. A write is accepted on a rising wr_clk edge when wr_en_n = 0 and full_n = 1.
- R3: A write attempted while full_n = 0 stores nothing. No extra word appears later in the read stream.
- R4: rd_data keeps its value on every read-clock edge where rd_en_n = 1. It also keeps its value when a read is attempted while empty_n = 0.
- R5: empty_n is 0 whenever the stored count is 0 and full_n is 0 whenever the count is DEPTH. Each of these flags falls on the edge of its own clock that completes the transition: read clock for empty, write clock for full.
- R6: After a word is written into an empty buffer, empty_n rises within four read-clock edges of the write edge. A read issued in the next read-clock cycle delivers that word.
- R7: aempty_n is 0 whenever the count is at most n, where n is the effective empty offset. It falls only on read-clock edges with a read.
- R8: afull_n is 0 whenever the count is at least DEPTH - m, where m is the effective full offset. It falls only on write-clock edges with a write.
- R9: half_n is 0 whenever the count exceeds DEPTH/2. It falls only on write-clock edges with a write.
- R10: A flag that the opposite side clears returns to 1 within four cycles of its own clock once the count has left its condition. Empty and almost-empty are cleared by writes; half, almost-full and full are cleared by reads.
- R11: With ofs_prog = 0, both offsets take the default: 31 for DEPTH 256, 63 for DEPTH 512, and 127 for larger depths. With ofs_prog = 1 they come from empty_ofs and full_ofs.
- R12: rd_data is 0 while out_en_n = 1 and shows the output register while out_en_n = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Write strobe, low to push |
| wr_data | input | DW | Word to push |
| rd_clk | input | 1 | Read-side clock |
| rd_en_n | input | 1 | Read strobe, low to pull |
| out_en_n | input | 1 | Output enable, low to drive rd_data |
| rd_data | output | DW | Registered read word, zero when disabled |
| rst_n | input | 1 | Active-low asynchronous reset |
| ofs_prog | input | 1 | 1 selects the supplied offsets, 0 the defaults |
| empty_ofs | input | log2(DEPTH) | Almost-empty offset n |
| full_ofs | input | log2(DEPTH) | Almost-full offset m |
| empty_n | output | 1 | Low when empty |
| aempty_n | output | 1 | Low when count is at most n |
| half_n | output | 1 | Low when count exceeds DEPTH/2 |
| afull_n | output | 1 | Low when count is at least DEPTH - m |
| full_n | output | 1 | Low when full |

## Verification
A read loads rd_data on the read edge and the bench compares it at the following read-clock falling edge. A write counts as accepted if full_n was high at the falling edge before the write edge. Flags that set in their own domain appear right after that edge, so the bench checks them at every falling edge of their own clock, but only in the direction they must hold: for example, whenever the bench's own count is at or above a threshold, that flag must be low. Releases lag by two synchronizer stages plus a flag register, so the exact value of every flag is compared only after both sides have been idle for at least four cycles of each clock. The first-word check counts read edges after the write until empty_n rises and requires that count to be four or fewer.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    // Wide enough for a 4096-deep buffer plus its wrap bit.
    typedef logic [15:0] ptr_wide_t;

    function automatic ptr_wide_t to_gray(ptr_wide_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_wide_t from_gray(ptr_wide_t g);
        ptr_wide_t b;
        b[15] = g[15];
        for (int i = 14; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Threshold offset used when no programmed value is selected.
    function automatic int unsigned dflt_offset(int unsigned depth);
        if (depth <= 256) return 31;
        if (depth <= 512) return 63;
        return 127;
    endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;

endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_word,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);

    localparam int WORDS = 1 << AW;

    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge wr_clk) begin
        if (wr_en) cells[wr_addr] <= wr_word;
    end

    assign rd_word = cells[rd_addr];

endmodule

// File: rtl/xfifo_wr_ctrl.sv
module xfifo_wr_ctrl
    import xfifo_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic [AW:0]   rgray_sync,
    input  logic [AW-1:0] full_ofs,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          afull,
    output logic          half
);

    localparam int PW = AW + 1;
    localparam int CW = AW + 2;
    localparam logic [CW-1:0] CAP  = CW'(1) << AW;
    localparam logic [CW-1:0] HALF = CAP >> 1;

    typedef struct packed {
        logic [AW:0] ptr;
        logic [AW:0] gray;
        logic        full;
        logic        afull;
        logic        half;
    } wst_t;

    wst_t          st_d, st_q;
    logic          go;
    logic [AW:0]   rbin;
    logic [AW:0]   used;
    logic [CW-1:0] used_x;
    logic [CW-1:0] limit;

    always_comb begin
        st_d       = st_q;
        go         = !wr_en_n && !st_q.full;
        st_d.ptr   = st_q.ptr + PW'(go);
        st_d.gray  = PW'(to_gray(ptr_wide_t'(st_d.ptr)));
        rbin       = PW'(from_gray(ptr_wide_t'(rgray_sync)));
        // Count seen from the write side never undercounts.
        used       = st_d.ptr - rbin;
        used_x     = CW'(used);
        limit      = CAP - CW'(full_ofs);
        st_d.full  = (used_x == CAP);
        st_d.afull = (used_x >= limit);
        st_d.half  = (used_x > HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we    = go;
    assign mem_waddr = st_q.ptr[AW-1:0];
    assign wgray     = st_q.gray;
    assign full      = st_q.full;
    assign afull     = st_q.afull;
    assign half      = st_q.half;

endmodule

// File: rtl/xfifo_rd_ctrl.sv
module xfifo_rd_ctrl
    import xfifo_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_n,
    input  logic [AW:0]   wgray_sync,
    input  logic [AW-1:0] empty_ofs,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          aempty,
    output logic [DW-1:0] dout
);

    localparam int PW = AW + 1;

    typedef struct packed {
        logic [AW:0]   ptr;
        logic [AW:0]   gray;
        logic          empty;
        logic          aempty;
        logic [DW-1:0] dout;
    } rst_t;

    rst_t        st_d, st_q;
    logic        go;
    logic [AW:0] wbin;
    logic [AW:0] used;

    always_comb begin
        st_d        = st_q;
        go          = !rd_en_n && !st_q.empty;
        st_d.ptr    = st_q.ptr + PW'(go);
        st_d.gray   = PW'(to_gray(ptr_wide_t'(st_d.ptr)));
        wbin        = PW'(from_gray(ptr_wide_t'(wgray_sync)));
        // Count seen from the read side never overcounts.
        used        = wbin - st_d.ptr;
        st_d.empty  = (used == '0);
        st_d.aempty = (used <= PW'(empty_ofs));
        st_d.dout   = go ? mem_rdata : st_q.dout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.empty  <= 1'b1;
            st_q.aempty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_raddr = st_q.ptr[AW-1:0];
    assign rgray     = st_q.gray;
    assign empty     = st_q.empty;
    assign aempty    = st_q.aempty;
    assign dout      = st_q.dout;

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xfifo_pkg::*;
#(
    parameter  int DEPTH = 256,
    parameter  int DW    = 18,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_en_n,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_en_n,
    input  logic          out_en_n,
    output logic [DW-1:0] rd_data,
    input  logic          rst_n,
    input  logic          ofs_prog,
    input  logic [AW-1:0] empty_ofs,
    input  logic [AW-1:0] full_ofs,
    output logic          empty_n,
    output logic          aempty_n,
    output logic          half_n,
    output logic          afull_n,
    output logic          full_n
);

    localparam logic [AW-1:0] DFLT_OFS = AW'(dflt_offset(DEPTH));

    logic [AW:0]   wgray, wgray_s, rgray, rgray_s;
    logic          mem_we;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] mem_q, rd_dout;
    logic          w_full, w_afull, w_half, r_empty, r_aempty;
    logic [AW-1:0] eff_e, eff_f;

    assign eff_e = ofs_prog ? empty_ofs : DFLT_OFS;
    assign eff_f = ofs_prog ? full_ofs  : DFLT_OFS;

    xfifo_ram #(.AW(AW), .DW(DW)) u_ram (
        .wr_clk (wr_clk),
        .wr_en  (mem_we),
        .wr_addr(waddr),
        .wr_word(wr_data),
        .rd_addr(raddr),
        .rd_word(mem_q)
    );

    xfifo_wr_ctrl #(.AW(AW)) u_wr (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .wr_en_n   (wr_en_n),
        .rgray_sync(rgray_s),
        .full_ofs  (eff_f),
        .mem_we    (mem_we),
        .mem_waddr (waddr),
        .wgray     (wgray),
        .full      (w_full),
        .afull     (w_afull),
        .half      (w_half)
    );

    xfifo_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .rd_en_n   (rd_en_n),
        .wgray_sync(wgray_s),
        .empty_ofs (eff_e),
        .mem_rdata (mem_q),
        .mem_raddr (raddr),
        .rgray     (rgray),
        .empty     (r_empty),
        .aempty    (r_aempty),
        .dout      (rd_dout)
    );

    xfifo_sync #(.W(AW + 1)) u_w2r (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .async_in(wgray),
        .sync_out(wgray_s)
    );

    xfifo_sync #(.W(AW + 1)) u_r2w (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .async_in(rgray),
        .sync_out(rgray_s)
    );

    assign rd_data  = out_en_n ? '0 : rd_dout;
    assign empty_n  = !r_empty;
    assign aempty_n = !r_aempty;
    assign half_n   = !w_half;
    assign afull_n  = !w_afull;
    assign full_n   = !w_full;

endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
    parameter int DW = 18
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en_n,
    input logic          rd_en_n,
    input logic          out_en_n,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] dout,
    input logic          empty_n,
    input logic          aempty_n,
    input logic          half_n,
    input logic          afull_n,
    input logic          full_n
);

    AST_EMPTY_NEEDS_READ: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $fell(empty_n) |-> !$past(rd_en_n)); // R5

    AST_FULL_NEEDS_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(full_n) |-> !$past(wr_en_n)); // R5

    AST_AE_NEEDS_READ: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $fell(aempty_n) |-> !$past(rd_en_n)); // R7

    AST_AF_NEEDS_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(afull_n) |-> !$past(wr_en_n)); // R8

    AST_HF_NEEDS_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(half_n) |-> !$past(wr_en_n)); // R9

    AST_EMPTY_IMPLIES_AE: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n); // R7

    AST_FULL_IMPLIES_AF_HF: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> (!afull_n && !half_n)); // R8

    AST_HOLD_OUTPUT: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en_n || !empty_n) |=> $stable(dout)); // R4

    AST_OE_BLANKS: assert property (@(posedge rd_clk) disable iff (!rst_n)
        out_en_n |-> (rd_data == '0)); // R12

endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW)) u_chk (
    .wr_clk  (wr_clk),
    .rd_clk  (rd_clk),
    .rst_n   (rst_n),
    .wr_en_n (wr_en_n),
    .rd_en_n (rd_en_n),
    .out_en_n(out_en_n),
    .rd_data (rd_data),
    .dout    (rd_dout),
    .empty_n (empty_n),
    .aempty_n(aempty_n),
    .half_n  (half_n),
    .afull_n (afull_n),
    .full_n  (full_n)
);

// File: tb/xclk_fifo_test.sv
module xclk_fifo_test;

    localparam int DEPTH = 256;
    localparam int DW    = 18;
    localparam int AW    = 8;

    logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic          wr_en_n = 1'b1, rd_en_n = 1'b1, out_en_n = 1'b0, ofs_prog = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] empty_ofs = '0, full_ofs = '0;
    logic          empty_n, aempty_n, half_n, afull_n, full_n;

    int            checks = 0, fails = 0;
    int            n_ofs, m_ofs;
    logic [DW-1:0] q[$];
    logic [DW-1:0] last = '0;
    int unsigned   seed_dummy;

    xclk_fifo #(.DEPTH(DEPTH), .DW(DW)) uut (
        .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_en_n(rd_en_n), .out_en_n(out_en_n), .rd_data(rd_data),
        .rst_n(rst_n), .ofs_prog(ofs_prog), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .empty_n(empty_n), .aempty_n(aempty_n), .half_n(half_n),
        .afull_n(afull_n), .full_n(full_n)
    );

    // 50 MHz write clock on even ns; read clock edges fall on odd ns.
    always #10 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #14 rd_clk = ~rd_clk;
    end

    function automatic int bench_dflt(int d);
        if (d == 256) return 31;
        if (d == 512) return 63;
        return 127;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_reset(bit prog, int n, int m);
        rst_n     = 1'b0;
        wr_en_n   = 1'b1;
        rd_en_n   = 1'b1;
        out_en_n  = 1'b0;
        ofs_prog  = prog;
        empty_ofs = AW'(n);
        full_ofs  = AW'(m);
        n_ofs     = prog ? n : bench_dflt(DEPTH);
        m_ofs     = prog ? m : bench_dflt(DEPTH);
        q.delete();
        last = '0;
        repeat (3) @(negedge wr_clk);
        #6 rst_n = 1'b1;
    endtask

    // One write-clock cycle; flags set by writes are checked one way.
    task automatic wr_cycle(bit en, logic [DW-1:0] d);
        bit acc;
        int cnt;
        @(negedge wr_clk);
        cnt = q.size();
        if (cnt >= DEPTH - m_ofs) check(afull_n == 1'b0, "R8", "afull_n at threshold", int'(afull_n), 0);
        if (cnt > DEPTH / 2)      check(half_n == 1'b0, "R9", "half_n above half", int'(half_n), 0);
        if (cnt == DEPTH)         check(full_n == 1'b0, "R5", "full_n when full", int'(full_n), 0);
        wr_en_n = !en;
        wr_data = d;
        acc     = en && full_n;
        @(posedge wr_clk);
        #2;
        wr_en_n = 1'b1;
        if (acc) q.push_back(d);
    endtask

    // One read-clock cycle; data and flags set by reads are checked.
    task automatic rd_cycle(bit en);
        bit acc;
        int cnt;
        @(negedge rd_clk);
        cnt = q.size();
        if (cnt == 0)     check(empty_n == 1'b0, "R5", "empty_n when empty", int'(empty_n), 0);
        if (cnt <= n_ofs) check(aempty_n == 1'b0, "R7", "aempty_n at threshold", int'(aempty_n), 0);
        check(rd_data == last, "R2 R4", "rd_data", int'(rd_data), int'(last));
        rd_en_n = !en;
        acc     = en && empty_n;
        @(posedge rd_clk);
        #2;
        rd_en_n = 1'b1;
        if (acc) begin
            if (q.size() == 0) check(1'b0, "R5", "read accepted from empty buffer", 1, 0);
            else               last = q.pop_front();
        end
    endtask

    // Idle both sides long enough for every release, then compare exactly.
    task automatic settle(string req);
        int c;
        repeat (6) @(negedge wr_clk);
        @(negedge rd_clk);
        c = q.size();
        check(empty_n  == !(c == 0),          "R5 R10",  {req, " empty_n"},  int'(empty_n),  int'(!(c == 0)));
        check(aempty_n == !(c <= n_ofs),      "R7 R10",  {req, " aempty_n"}, int'(aempty_n), int'(!(c <= n_ofs)));
        check(half_n   == !(c > DEPTH / 2),   "R9 R10",  {req, " half_n"},   int'(half_n),   int'(!(c > DEPTH / 2)));
        check(afull_n  == !(c >= DEPTH - m_ofs), "R8 R10", {req, " afull_n"}, int'(afull_n), int'(!(c >= DEPTH - m_ofs)));
        check(full_n   == !(c == DEPTH),      "R5 R10",  {req, " full_n"},   int'(full_n),   int'(!(c == DEPTH)));
    endtask

    function automatic bit is_key(int c);
        return c == 0 || c == 1 || c == n_ofs || c == n_ofs + 1 || c == DEPTH / 2 ||
               c == DEPTH / 2 + 1 || c == DEPTH - m_ofs - 1 || c == DEPTH - m_ofs || c == DEPTH;
    endfunction

    initial begin
        seed_dummy = $urandom(32'd4711);

        // R1: reset state with default offsets.
        apply_reset(1'b0, 0, 0);
        @(negedge rd_clk);
        check(empty_n == 1'b0,  "R1", "empty_n after reset",  int'(empty_n), 0);
        check(aempty_n == 1'b0, "R1", "aempty_n after reset", int'(aempty_n), 0);
        check(half_n == 1'b1,   "R1", "half_n after reset",   int'(half_n), 1);
        check(afull_n == 1'b1,  "R1", "afull_n after reset",  int'(afull_n), 1);
        check(full_n == 1'b1,   "R1", "full_n after reset",   int'(full_n), 1);
        check(rd_data == '0,    "R1", "rd_data after reset",  int'(rd_data), 0);

        // R6: first word latency into an empty buffer.
        begin
            int k = 0;
            wr_cycle(1'b1, 18'h2A5C1);
            for (int i = 1; i <= 6; i++) begin
                @(negedge rd_clk);
                k = i;
                if (empty_n) break;
            end
            check(k <= 4, "R6", "read edges until empty_n rises", k, 4);
            check(rd_data == '0, "R4", "rd_data before first read", int'(rd_data), 0);
            rd_en_n = 1'b0;
            @(posedge rd_clk);
            #2;
            rd_en_n = 1'b0;
            rd_en_n = 1'b1;
            last = q.pop_front();
            rd_cycle(1'b0);
            check(rd_data == 18'h2A5C1, "R6", "first word", int'(rd_data), 'h2A5C1);
        end

        // Directed fill with default offsets (R11) to full.
        for (int i = 0; i < DEPTH; i++) begin
            wr_cycle(1'b1, DW'(i * 7 + 3));
            if (is_key(q.size())) settle("R11 fill");
        end
        // R3: writes while full are dropped.
        repeat (3) wr_cycle(1'b1, 18'h3FFFF);
        settle("R3 full");
        check(q.size() == DEPTH, "R3", "model count at full", q.size(), DEPTH);

        // R12: output enable gates rd_data.
        rd_cycle(1'b1);
        out_en_n = 1'b1;
        @(negedge rd_clk);
        check(rd_data == '0, "R12", "rd_data while disabled", int'(rd_data), 0);
        out_en_n = 1'b0;
        @(negedge rd_clk);
        check(rd_data == last, "R12", "rd_data re-enabled", int'(rd_data), int'(last));
        repeat (3) rd_cycle(1'b0);

        // Directed drain; extra reads on empty must not move rd_data (R4).
        while (q.size() > 0) begin
            rd_cycle(1'b1);
            if (is_key(q.size())) settle("R11 drain");
        end
        repeat (4) rd_cycle(1'b1);
        settle("R4 empty");

        // Random traffic with programmed offsets (R11).
        for (int ph = 0; ph < 2; ph++) begin
            int wb = (ph == 0) ? 75 : 40;
            int rb = (ph == 0) ? 45 : 85;
            apply_reset(1'b1, (ph == 0) ? 5 : 100, (ph == 0) ? 10 : 40);
            fork
                for (int i = 0; i < 2500; i++)
                    wr_cycle(($urandom % 100) < wb, DW'($urandom));
                for (int i = 0; i < 1780; i++)
                    rd_cycle(($urandom % 100) < rb);
            join
            settle("R11 random");
            while (q.size() > 0) rd_cycle(1'b1);
            rd_cycle(1'b0);
            settle("R2 drained");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #4000000;
        fails++;
        $display("FAIL R2 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule